// File: doc/BRIEF.md
# Operand Forwarding and Load-Hazard Unit

This block sits beside the decode and execute stages of a five-stage in-order pipeline. Its job is to steer operand multiplexers so that an instruction in execute sees results that are still moving down the pipe. It looks at the source register fields of the instructions in decode and execute. It compares them with the destination fields and control flags held in the later pipeline registers. The register file, the ALU and the multiplexers themselves sit outside the block. It is purely combinational: every output follows its inputs within the same cycle.

Each ALU operand gets a two-bit source select: register file, write-back stage, or memory stage. The memory-stage result is newer than the write-back one, so it wins when both match. A separate one-bit select drives a multiplexer placed in front of data memory on the store-data path. That mux replaces the rt value a store read from the register file with the value a load is writing back. A store takes its address from rs plus the immediate, so an ALU rt forward never reaches the stored data. When a load in execute feeds the instruction in decode, the unit asks for a one-cycle bubble. It holds the PC and the decode register, and it clears the execute-stage control bits. This also covers a load followed by a store of the same register, because the decode stage cannot yet tell a store apart.

Top module: `fwd_hazard_unit`

## Requirements
- R1: `alu_a_sel` is 2'b10 when `mem_wr_en`=1, `mem_dst`≠0 and `mem_dst`=`ex_rs`. Otherwise it is 2'b01 when `wb_wr_en`=1, `wb_dst`≠0 and `wb_dst`=`ex_rs`. Otherwise it is 2'b00. The value 2'b11 never appears.
- R2: `alu_b_sel` follows the same rule and encoding as R1, with `ex_rt` in place of `ex_rs`.
- R3: When the memory-stage and write-back-stage destinations both match an operand under the conditions of R1/R2, the select is 2'b10 (the memory stage wins).
- R4: Register 0 is never a forwarding source. A zero source field, or a zero destination, yields select 2'b00. With every input at zero, every output is 0.
- R5: `hold_front` is 1 exactly when `ex_load`=1, `ex_rt`≠0, and `ex_rt` equals `id_rs` or `id_rt`. `insert_bubble` always equals `hold_front`.
- R6: The stall does not depend on what kind of instruction is in decode or on the store flag. A match on `id_rt` alone, with `ex_store` at either value, raises the stall.
- R7: `store_data_fwd` is 1 exactly when `ex_store`=1, `wb_load`=1, `ex_rt`≠0 and `wb_dst`=`ex_rt`.
- R8: `store_data_fwd` stays 0 when a non-load producer in write-back matches the store's rt (`wb_load`=0), even while `alu_b_sel` is 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs | input | REG_AW | First source field of the instruction in decode |
| id_rt | input | REG_AW | Second source field of the instruction in decode |
| ex_rs | input | REG_AW | First source field held in the decode/execute register |
| ex_rt | input | REG_AW | Second source field (load destination, store data register) in decode/execute |
| ex_load | input | 1 | Instruction in execute reads memory |
| ex_store | input | 1 | Instruction in execute writes memory |
| mem_dst | input | REG_AW | Destination field held in the execute/memory register |
| mem_wr_en | input | 1 | Instruction in memory stage writes a register |
| wb_dst | input | REG_AW | Destination field held in the memory/write-back register (rt for a load) |
| wb_wr_en | input | 1 | Instruction in write-back writes a register |
| wb_load | input | 1 | Read-memory flag carried into write-back |
| alu_a_sel | output | 2 | ALU first operand source: 00 register file, 01 write-back, 10 memory stage |
| alu_b_sel | output | 2 | ALU second operand source, same encoding |
| store_data_fwd | output | 1 | Replace store data with the write-back value |
| hold_front | output | 1 | Freeze the PC and the fetch/decode register |
| insert_bubble | output | 1 | Clear the control bits entering execute |

## Verification
The assertions assume that all inputs are known 0/1 values, and they check nothing while any input is X. They also assume the flags describe one instruction per stage. They do not assume the load and store flags are exclusive, so any flag combination is legal. The stimulus drives every input combination of a 2-bit register field build. It changes the inputs only after a rising edge and compares at the falling edge, so no input is ever undefined when an output is judged.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_WB      = 2'b01,
      SRC_MEM     = 2'b10
   } src_sel_e;

   localparam int unsigned NUM_ALU_OPS = 2;

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] src_reg,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr_en,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wr_en,
   output src_sel_e          sel
);

   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic src_live;
   logic hit_mem;
   logic hit_wb;

   assign src_live = (src_reg != ZERO_REG);
   assign hit_mem  = mem_wr_en && src_live && (mem_dst == src_reg);
   assign hit_wb   = wb_wr_en  && src_live && (wb_dst  == src_reg);

   always_comb begin
      if (hit_mem)     sel = SRC_MEM;
      else if (hit_wb) sel = SRC_WB;
      else             sel = SRC_REGFILE;
   end

   always_comb begin
      if (!$isunknown({src_reg, mem_dst, mem_wr_en, wb_dst, wb_wr_en})) begin
         AST_SEL_ENCODING: assert (sel != src_sel_e'(2'b11)) else $error("illegal select"); // R1
         AST_ZERO_NOT_SOURCE: assert (src_reg != ZERO_REG || sel == SRC_REGFILE) else $error("r0 forwarded"); // R4
         AST_MEM_WINS: assert (!(mem_wr_en && mem_dst == src_reg && src_live) || sel == SRC_MEM) else $error("priority"); // R3
      end
   end

endmodule

// File: rtl/fwd_load_stall.sv
module fwd_load_stall #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic              ex_load,
   output logic              stall
);

   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic dst_live;
   logic uses_dst;

   assign dst_live = (ex_rt != ZERO_REG);
   assign uses_dst = (ex_rt == id_rs) || (ex_rt == id_rt);
   assign stall    = ex_load && dst_live && uses_dst;

   always_comb begin
      if (!$isunknown({id_rs, id_rt, ex_rt, ex_load})) begin
         AST_STALL_NEEDS_LOAD: assert (!stall || ex_load) else $error("stall without load"); // R5
         AST_STALL_NOT_ON_ZERO: assert (!stall || ex_rt != ZERO_REG) else $error("stall on r0"); // R4
      end
   end

endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
   parameter int unsigned REG_AW = 5
) (
   input  logic [REG_AW-1:0] ex_rt,
   input  logic              ex_store,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_load,
   output logic              fwd
);

   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   assign fwd = ex_store && wb_load && (ex_rt != ZERO_REG) && (wb_dst == ex_rt);

   always_comb begin
      if (!$isunknown({ex_rt, ex_store, wb_dst, wb_load})) begin
         AST_STORE_FWD_FROM_LOAD: assert (!fwd || (wb_load && ex_store)) else $error("store fwd w/o load"); // R7
         AST_STORE_FWD_NON_LOAD: assert (wb_load || !fwd) else $error("store fwd from alu op"); // R8
      end
   end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW       = 5,
   parameter bit          STORE_FWD_EN = 1'b1
) (
   input  logic [REG_AW-1:0] id_rs,
   input  logic [REG_AW-1:0] id_rt,
   input  logic [REG_AW-1:0] ex_rs,
   input  logic [REG_AW-1:0] ex_rt,
   input  logic              ex_load,
   input  logic              ex_store,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wr_en,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wr_en,
   input  logic              wb_load,
   output logic [1:0]        alu_a_sel,
   output logic [1:0]        alu_b_sel,
   output logic              store_data_fwd,
   output logic              hold_front,
   output logic              insert_bubble
);

   localparam int unsigned MAX_REG_AW = 8;

   if (REG_AW < 1 || REG_AW > MAX_REG_AW) begin : g_bad_width
      $error("REG_AW out of range");
   end

   logic [REG_AW-1:0] op_src [NUM_ALU_OPS];
   src_sel_e          op_sel [NUM_ALU_OPS];
   logic              stall;

   assign op_src[0] = ex_rs;
   assign op_src[1] = ex_rt;

   for (genvar g = 0; g < NUM_ALU_OPS; g++) begin : g_op
      fwd_operand_sel #(.REG_AW(REG_AW)) u_sel (
         .src_reg   (op_src[g]),
         .mem_dst   (mem_dst),
         .mem_wr_en (mem_wr_en),
         .wb_dst    (wb_dst),
         .wb_wr_en  (wb_wr_en),
         .sel       (op_sel[g])
      );
   end

   assign alu_a_sel = op_sel[0];
   assign alu_b_sel = op_sel[1];

   if (STORE_FWD_EN) begin : g_store_fwd
      fwd_store_sel #(.REG_AW(REG_AW)) u_store (
         .ex_rt    (ex_rt),
         .ex_store (ex_store),
         .wb_dst   (wb_dst),
         .wb_load  (wb_load),
         .fwd      (store_data_fwd)
      );
   end else begin : g_no_store_fwd
      assign store_data_fwd = 1'b0;
   end

   fwd_load_stall #(.REG_AW(REG_AW)) u_stall (
      .id_rs   (id_rs),
      .id_rt   (id_rt),
      .ex_rt   (ex_rt),
      .ex_load (ex_load),
      .stall   (stall)
   );

   assign hold_front    = stall;
   assign insert_bubble = stall;

   always_comb begin
      if (!$isunknown({id_rs, id_rt, ex_rt, ex_load})) begin
         AST_HOLD_EQ_BUBBLE: assert (hold_front == insert_bubble) else $error("hold/bubble split"); // R5
      end
   end

endmodule

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;

   localparam int unsigned AW = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, mem_dst, wb_dst;
   logic ex_load, ex_store, mem_wr_en, wb_wr_en, wb_load;
   logic [1:0] alu_a_sel, alu_b_sel;
   logic store_data_fwd, hold_front, insert_bubble;

   int checks = 0;
   int bad    = 0;
   bit done   = 1'b0;

   fwd_hazard_unit #(.REG_AW(AW), .STORE_FWD_EN(1'b1)) dut (
      .id_rs(id_rs), .id_rt(id_rt), .ex_rs(ex_rs), .ex_rt(ex_rt),
      .ex_load(ex_load), .ex_store(ex_store),
      .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
      .wb_dst(wb_dst), .wb_wr_en(wb_wr_en), .wb_load(wb_load),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
      .store_data_fwd(store_data_fwd), .hold_front(hold_front),
      .insert_bubble(insert_bubble)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_sel(input int src, input int md, input int mw, input int wd, input int ww);
      if (mw != 0 && src != 0 && md == src) return 2;
      if (ww != 0 && src != 0 && wd == src) return 1;
      return 0;
   endfunction

   task automatic apply(input int v);
      @(posedge clk);
      id_rs     = AW'(v);
      id_rt     = AW'(v >> 2);
      ex_rs     = AW'(v >> 4);
      ex_rt     = AW'(v >> 6);
      mem_dst   = AW'(v >> 8);
      wb_dst    = AW'(v >> 10);
      ex_load   = v[12];
      ex_store  = v[13];
      mem_wr_en = v[14];
      wb_wr_en  = v[15];
      wb_load   = v[16];
      @(negedge clk);
   endtask

   initial begin
      // R4: all-zero inputs give all-zero outputs
      apply(0);
      chk("R4 idle a", alu_a_sel, 0);
      chk("R4 idle b", alu_b_sel, 0);
      chk("R4 idle st", store_data_fwd, 0);
      chk("R4 idle hold", hold_front, 0);

      // Exhaustive sweep of the 2-bit register build
      for (int v = 0; v < (1 << 17); v++) begin
         int e_a, e_b, e_st, e_stall;
         apply(v);
         e_a = exp_sel(int'(ex_rs), int'(mem_dst), int'(mem_wr_en), int'(wb_dst), int'(wb_wr_en));
         e_b = exp_sel(int'(ex_rt), int'(mem_dst), int'(mem_wr_en), int'(wb_dst), int'(wb_wr_en));
         e_st = (ex_store && wb_load && ex_rt != 0 && wb_dst == ex_rt) ? 1 : 0;
         e_stall = (ex_load && ex_rt != 0 && (ex_rt == id_rs || ex_rt == id_rt)) ? 1 : 0;
         chk("R1/R3/R4 alu_a_sel", alu_a_sel, e_a);
         chk("R2/R3/R4 alu_b_sel", alu_b_sel, e_b);
         chk("R7 store_data_fwd", store_data_fwd, e_st);
         chk("R5 hold_front", hold_front, e_stall);
         chk("R5 insert_bubble", insert_bubble, e_stall);
      end

      // R3: both stages write ex_rs=1 -> memory stage wins
      // bits: ex_rs=1 (<<4), mem_dst=1 (<<8), wb_dst=1 (<<10), mem_wr_en, wb_wr_en
      apply((1 << 4) | (1 << 8) | (1 << 10) | (1 << 14) | (1 << 15));
      chk("R3 priority", alu_a_sel, 2);

      // R6: load r2 in EX, decode reads r2 via rt only, store flag set
      apply((2 << 2) | (2 << 6) | (1 << 12) | (1 << 13));
      chk("R6 rt-only stall", hold_front, 1);
      chk("R6 rt-only bubble", insert_bubble, 1);

      // R8: ALU producer of r3 in WB, store of r3 in EX: ALU fwd yes, store fwd no
      apply((3 << 6) | (3 << 10) | (1 << 13) | (1 << 15));
      chk("R8 store fwd suppressed", store_data_fwd, 0);
      chk("R8 b from wb", alu_b_sel, 1);

      // R7: load of r3 in WB, store of r3 in EX
      apply((3 << 6) | (3 << 10) | (1 << 13) | (1 << 15) | (1 << 16));
      chk("R7 store fwd", store_data_fwd, 1);

      // R4: load to r0 in WB with store of r0: no forward, no stall
      apply((1 << 12) | (1 << 13) | (1 << 15) | (1 << 16));
      chk("R4 r0 store", store_data_fwd, 0);
      chk("R4 r0 stall", hold_front, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule